// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block produces a 32-bit effective address for a load or store from operand values that an upstream decoder has already extracted. The decoder presents an addressing mode, the value of the base register, the number and the value of the index register, a 2-bit scale code and a displacement with a width flag. One cycle later the block presents the sum that the mode calls for, with a valid strobe and a flag that marks an encoding the mode does not allow.

Five modes exist: register indirect, base plus displacement, scaled index plus displacement, base plus scaled index, and base plus scaled index plus displacement. The scaled index is the index value shifted left by the scale code, which gives factors of 1, 2, 4 and 8. A displacement is either a narrow signed byte or a full 32-bit word. The legality rules cover three cases: the stack-pointer register as index, a byte displacement in the mode that has no base register, and the unused mode codes. Segment offsets and memory access are left to the blocks that follow.

Top module: `scaled_agu`

## Requirements
- R1: After reset and before the first accepted request, `out_valid`, `eff_addr` and `illegal` are all zero.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: For legal requests, `eff_addr` is computed modulo 2^32 by mode code: 0 gives base; 1 gives base + disp; 2 gives scaled index + disp, with the base value ignored; 3 gives base + scaled index, with the displacement ignored; 4 gives base + scaled index + disp. Any register value is accepted as the base.
- R4: The scaled index is `index_val` shifted left by `scale_code` (0..3), that is, multiplied by 1, 2, 4 or 8.
- R5: With `disp_wide` = 0 only `disp[7:0]` is used, sign-extended from bit 7, and `disp[31:8]` has no effect. With `disp_wide` = 1 all 32 bits of `disp` are used.
- R6: In modes 2, 3 and 4 an `index_sel` of 4 (the stack pointer) sets `illegal`. In modes 0 and 1, `index_sel`, `index_val` and `scale_code` have no effect.
- R7: Mode 2 with `disp_wide` = 0 sets `illegal`.
- R8: Mode codes 5, 6 and 7 set `illegal`.
- R9: When `illegal` is set, `eff_addr` is zero.
- R10: In a cycle with `in_valid` low, `eff_addr` and `illegal` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code (0..4 defined) |
| base_val | input | 32 | Base register value |
| index_sel | input | 3 | Index register number (4 = stack pointer) |
| index_val | input | 32 | Index register value |
| scale_code | input | 2 | Left shift applied to the index |
| disp | input | 32 | Displacement; the low byte only when narrow |
| disp_wide | input | 1 | 1 = 32-bit displacement, 0 = 8-bit |
| out_valid | output | 1 | Result valid, one cycle after the request |
| eff_addr | output | 32 | Effective address, zero when illegal |
| illegal | output | 1 | Request encoding not allowed |

## Verification
The bench targets narrow displacements with bit 7 set and junk in the upper bytes. A design that zero-extends these, or that uses the upper bytes, gives an address off by 256 or more. It sends index register 4 in every mode: a design that flags it everywhere rejects legal base-only requests, and one that never flags it returns an address built on the stack pointer. Sums that cross 2^32, scale code 3 with a large index, and mode 2 with a nonzero base value expose carry handling, a wrong shift amount and a base leaking into the sum. Idle cycles with changed inputs expose a result register that does not hold.

// File: rtl/scaled_agu_pkg.sv
package scaled_agu_pkg;

    localparam int ADDR_W   = 32;
    localparam int REG_W    = 3;
    localparam int SCALE_W  = 2;
    localparam int NARROW_W = 8;
    localparam int MODE_W   = 3;
    localparam int SP_REG   = 4;

    typedef enum logic [MODE_W-1:0] {
        AM_REG_IND   = 3'd0,
        AM_BASE_DISP = 3'd1,
        AM_IDX_DISP  = 3'd2,
        AM_BASE_IDX  = 3'd3,
        AM_FULL      = 3'd4
    } agu_mode_e;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] ea;
        logic              ill;
    } agu_out_t;

endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext #(
    parameter int AW = 32,
    parameter int NW = 8
) (
    input  logic [AW-1:0] disp_raw,
    input  logic          wide,
    output logic [AW-1:0] disp_ext
);
    localparam int PAD = AW - NW;

    always_comb begin
        if (wide) disp_ext = disp_raw;
        else      disp_ext = {{PAD{disp_raw[NW-1]}}, disp_raw[NW-1:0]};
    end
endmodule

// File: rtl/agu_scaler.sv
module agu_scaler #(
    parameter int AW = 32,
    parameter int SW = 2
) (
    input  logic [AW-1:0] idx,
    input  logic [SW-1:0] code,
    output logic [AW-1:0] scaled
);
    localparam int NSTEP = 1 << SW;

    logic [AW-1:0] cand [NSTEP];

    for (genvar g = 0; g < NSTEP; g++) begin : g_step
        assign cand[g] = idx << g;
    end

    assign scaled = cand[code];
endmodule

// File: rtl/agu_rules.sv
module agu_rules
    import scaled_agu_pkg::*;
#(
    parameter int RW    = 3,
    parameter int SP_ID = 4
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [RW-1:0]     index_sel,
    input  logic              wide,
    output logic              use_base,
    output logic              use_index,
    output logic              use_disp,
    output logic              bad
);
    logic known;

    always_comb begin
        known     = 1'b1;
        use_base  = 1'b0;
        use_index = 1'b0;
        use_disp  = 1'b0;
        case (mode)
            AM_REG_IND:   use_base = 1'b1;
            AM_BASE_DISP: begin use_base = 1'b1; use_disp = 1'b1; end
            AM_IDX_DISP:  begin use_index = 1'b1; use_disp = 1'b1; end
            AM_BASE_IDX:  begin use_base = 1'b1; use_index = 1'b1; end
            AM_FULL:      begin use_base = 1'b1; use_index = 1'b1; use_disp = 1'b1; end
            default:      known = 1'b0;
        endcase
        bad = !known
            || (use_index && index_sel == RW'(SP_ID))
            || (mode == AM_IDX_DISP && !wide);
    end
endmodule

// File: rtl/scaled_agu.sv
module scaled_agu
    import scaled_agu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [MODE_W-1:0]   mode,
    input  logic [ADDR_W-1:0]   base_val,
    input  logic [REG_W-1:0]    index_sel,
    input  logic [ADDR_W-1:0]   index_val,
    input  logic [SCALE_W-1:0]  scale_code,
    input  logic [ADDR_W-1:0]   disp,
    input  logic                disp_wide,
    output logic                out_valid,
    output logic [ADDR_W-1:0]   eff_addr,
    output logic                illegal
);
    logic [ADDR_W-1:0] disp_x;
    logic [ADDR_W-1:0] idx_sc;
    logic              use_base, use_index, use_disp, bad;
    agu_out_t          res_d, res_q;

    agu_disp_ext #(.AW(ADDR_W), .NW(NARROW_W)) u_disp (
        .disp_raw (disp),
        .wide     (disp_wide),
        .disp_ext (disp_x)
    );

    agu_scaler #(.AW(ADDR_W), .SW(SCALE_W)) u_scale (
        .idx    (index_val),
        .code   (scale_code),
        .scaled (idx_sc)
    );

    agu_rules #(.RW(REG_W), .SP_ID(SP_REG)) u_rules (
        .mode      (mode),
        .index_sel (index_sel),
        .wide      (disp_wide),
        .use_base  (use_base),
        .use_index (use_index),
        .use_disp  (use_disp),
        .bad       (bad)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        if (in_valid) begin
            res_d.ill = bad;
            if (bad) res_d.ea = '0;
            else     res_d.ea = (use_base  ? base_val : '0)
                              + (use_index ? idx_sc   : '0)
                              + (use_disp  ? disp_x   : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.vld;
    assign eff_addr  = res_q.ea;
    assign illegal   = res_q.ill;
endmodule

// File: rtl/scaled_agu_chk.sv
module scaled_agu_chk
    import scaled_agu_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [MODE_W-1:0]   mode,
    input logic [ADDR_W-1:0]   base_val,
    input logic [REG_W-1:0]    index_sel,
    input logic                disp_wide,
    input logic                out_valid,
    input logic [ADDR_W-1:0]   eff_addr,
    input logic                illegal
);
    logic idx_mode;
    assign idx_mode = (mode == 3'd2) || (mode == 3'd3) || (mode == 3'd4);

    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_reg_ind_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd0) |=> (!illegal && eff_addr == $past(base_val)));

    assert_sp_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && idx_mode && index_sel == REG_W'(SP_REG)) |=> illegal);

    assert_narrow_nobase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd2 && !disp_wide) |=> illegal);

    assert_reserved_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode > 3'd4) |=> illegal);

    assert_zero_when_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> eff_addr == '0);

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(eff_addr) && $stable(illegal)));
endmodule

bind scaled_agu scaled_agu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .base_val  (base_val),
    .index_sel (index_sel),
    .disp_wide (disp_wide),
    .out_valid (out_valid),
    .eff_addr  (eff_addr),
    .illegal   (illegal)
);

// File: tb/scaled_agu_bench.sv
module scaled_agu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [31:0] base_val = '0;
    logic [2:0]  index_sel = '0;
    logic [31:0] index_val = '0;
    logic [1:0]  scale_code = '0;
    logic [31:0] disp = '0;
    logic        disp_wide = 1'b0;
    logic        out_valid;
    logic [31:0] eff_addr;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    scaled_agu u_scaled_agu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .base_val(base_val), .index_sel(index_sel), .index_val(index_val),
        .scale_code(scale_code), .disp(disp), .disp_wide(disp_wide),
        .out_valid(out_valid), .eff_addr(eff_addr), .illegal(illegal)
    );

    function automatic bit ref_ill(input logic [2:0] m, input logic [2:0] is, input logic w);
        if (m > 3'd4) return 1'b1;
        if ((m >= 3'd2) && is == 3'd4) return 1'b1;
        if (m == 3'd2 && !w) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] ref_ea(input logic [2:0] m, input logic [31:0] b,
                                           input logic [31:0] iv, input logic [1:0] sc,
                                           input logic [31:0] d, input logic w);
        logic [31:0] dx, ix;
        dx = w ? d : {{24{d[7]}}, d[7:0]};
        ix = iv * (32'd1 << sc);
        case (m)
            3'd0: return b;
            3'd1: return b + dx;
            3'd2: return ix + dx;
            3'd3: return b + ix;
            default: return b + ix + dx;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at negedge, result visible after next posedge, sample at following negedge
    task automatic issue(input logic [2:0] m, input logic [31:0] b, input logic [2:0] is,
                         input logic [31:0] iv, input logic [1:0] sc, input logic [31:0] d,
                         input logic w, input string tag);
        bit          xi;
        logic [31:0] xe;
        in_valid = 1'b1; mode = m; base_val = b; index_sel = is; index_val = iv;
        scale_code = sc; disp = d; disp_wide = w;
        @(negedge clk);
        xi = ref_ill(m, is, w);
        xe = xi ? 32'd0 : ref_ea(m, b, iv, sc, d, w);
        check({tag, " R2 valid"}, {31'd0, out_valid}, 32'd1);
        check({tag, " illegal"}, {31'd0, illegal}, {31'd0, xi});
        check({tag, " eff_addr"}, eff_addr, xe);
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold_ea;
        logic        hold_ill;
        repeat (3) @(negedge clk);
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 eff_addr", eff_addr, 32'd0);
        check("R1 illegal", {31'd0, illegal}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        issue(3'd0, 32'h1234_5678, 3'd4, 32'hFFFF, 2'd3, 32'h55, 1'b1, "R3 R6 mode0 sp ignored");
        issue(3'd1, 32'h1000, 3'd4, 32'h7, 2'd2, 32'hAAAA_AA80, 1'b0, "R5 R6 narrow neg");
        issue(3'd1, 32'h1000, 3'd0, 32'h0, 2'd0, 32'h0000_007F, 1'b0, "R5 narrow pos");
        issue(3'd1, 32'hFFFF_FFFF, 3'd0, 32'h0, 2'd0, 32'h0000_0001, 1'b1, "R3 wrap");
        issue(3'd2, 32'hDEAD_BEEF, 3'd1, 32'h10, 2'd3, 32'h100, 1'b1, "R3 R4 mode2 base ignored");
        issue(3'd2, 32'h0, 3'd1, 32'h10, 2'd3, 32'h05, 1'b0, "R7 narrow no base");
        issue(3'd3, 32'h2000, 3'd7, 32'h3000_0001, 2'd3, 32'hFFFF, 1'b1, "R3 R4 scale8");
        issue(3'd3, 32'h2000, 3'd4, 32'h1, 2'd0, 32'h0, 1'b1, "R6 sp index");
        issue(3'd4, 32'h100, 3'd2, 32'h3, 2'd1, 32'hFFFF_FFFC, 1'b0, "R3 R5 full");
        issue(3'd4, 32'h100, 3'd4, 32'h3, 2'd1, 32'h4, 1'b1, "R6 full sp");
        issue(3'd5, 32'h100, 3'd0, 32'h3, 2'd1, 32'h4, 1'b1, "R8 mode5");
        issue(3'd7, 32'h100, 3'd0, 32'h3, 2'd1, 32'h4, 1'b1, "R8 R9 mode7");

        // idle hold after a legal result
        issue(3'd4, 32'h40, 3'd3, 32'h2, 2'd2, 32'h1, 1'b1, "R3 before idle");
        hold_ea = eff_addr; hold_ill = illegal;
        in_valid = 1'b0; mode = 3'd6; base_val = 32'h9999; disp = 32'h77;
        @(negedge clk);
        check("R2 idle valid low", {31'd0, out_valid}, 32'd0);
        check("R10 hold eff_addr", eff_addr, hold_ea);
        check("R10 hold illegal", {31'd0, illegal}, {31'd0, hold_ill});

        // random sweep
        for (int i = 0; i < 600; i++) begin
            logic [2:0] m;
            m = (($urandom % 8) == 0) ? 3'($urandom_range(5, 7)) : 3'($urandom % 5);
            issue(m, $urandom, 3'($urandom), $urandom, 2'($urandom), $urandom,
                  1'($urandom), "R3 R4 R5 R6 R7 R8 R9 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
    end
endmodule